// File: doc/BRIEF.md
# Grouped Peripheral Pin Remapping Crossbar

This block connects a set of internal digital peripheral signals to a bank of general-purpose pads through software-programmed mapping registers. Pads and peripheral signals are divided into four equal groups. A peripheral signal can only be routed to a pad in its own group, which keeps every multiplexer narrow. A remappable peripheral has no default pad. It stays disconnected until software assigns it: its input sees an idle level and its output reaches no pad.

Each pad's output driver is arbitrated in a fixed order. An enabled analog function always wins and turns the digital driver off. Below that, a remapped peripheral output takes precedence over the pad's fixed digital function. The fixed function drives the pad only when no remapped output is assigned. A small group of pads can only receive signals, so they never drive.

A register bus writes the mappings. A hardware lock blocks mapping writes until a key sequence opens it. A static configuration input can keep the lock closed until the next reset.

Top module: `pinmux_xbar`

## Requirements
- R1: Out of reset, the lock is closed (control register at address 0x7F reads 1), every pad output map reads 0, and every peripheral input map reads 0x0F. All peripheral inputs show their idle level (default 0), and each pad follows its fixed function.
- R2: Pads are grouped by index/12, and each group owns 4 peripheral outputs and 4 peripheral inputs. For a pad in group g, output code k in 1..4 selects peripheral output 4*g+k-1. Code 0 and codes 5..15 select no remapped function.
- R3: A peripheral input i in group i/4 with map code j routes pad 12*(i/4)+j combinationally, but only when j < 12 and that pad exists (index at most 46). Any other code gives the idle level.
- R4: When a pad has a remapped output, its data and enable come from that peripheral's output and output enable; otherwise from the pad's fixed data and enable. The pad registers update one clock edge after their inputs.
- R5: A pad with analog enabled has its output enable low one edge later, whatever is mapped to it.
- R6: Pads 41 to 45 are input-only. Writes to their output map registers are ignored, so they read back 0, and their output enable is never asserted.
- R7: While the lock is closed, writes to any mapping register leave its contents unchanged.
- R8: The lock opens only after three writes in a fixed order. First 0x55 to the key address 0x7E, then 0xAA to 0x7E on the very next cycle, then, as the next write, a 0 in bit 0 of 0x7F. Any other cycle or write in between restarts the sequence. Writing 1 to bit 0 of 0x7F closes the lock at any time.
- R9: While the keep-lock input is high, the lock cannot be opened.
- R10: Pad output maps sit at addresses 0..46 and peripheral input maps at 0x40..0x4F, in the low 4 bits. Read data is registered and appears one edge after the address. The key address and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| lock_keep | input | 1 | Configuration level that keeps the lock closed |
| pad_in | input | 47 | Pad input levels |
| analog_en | input | 47 | Analog function enabled per pad |
| fixed_out | input | 47 | Fixed digital function data per pad |
| fixed_oe | input | 47 | Fixed digital function output enable per pad |
| pad_out | output | 47 | Registered pad output data |
| pad_oe | output | 47 | Registered pad output enable |
| periph_out | input | 16 | Remappable peripheral output data |
| periph_oe | input | 16 | Remappable peripheral output enable |
| periph_in | output | 16 | Remappable peripheral input levels |

## Verification
Pad data and enables are due one edge after their stimulus or after the edge that stores a mapping write. Peripheral inputs follow pads within the same cycle once the map register holds its value. Read data is due one edge after the address, and the lock changes on the edge that takes the final write of the sequence. The bench drives all inputs on the falling edge and samples on the next falling edge, so each result is read after exactly the one rising edge that produces it.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int MAP_W    = 4;
  localparam int DATA_W   = 8;
  localparam int OUT_BASE = 0;
  localparam int IN_BASE  = 64;
  localparam int KEY_ADDR = 126;
  localparam int CTRL_ADDR = 127;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_st_e;
endpackage

// File: rtl/pinmux_lock.sv
module pinmux_lock
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              keep,
  output logic              lock_q
);
  unlock_st_e st_q, st_d;
  logic key_wr, ctrl_wr, open_ok;

  assign key_wr  = wr && (addr == ADDR_W'(KEY_ADDR));
  assign ctrl_wr = wr && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    st_d = st_q;
    case (st_q)
      UL_IDLE:  if (key_wr && wdata == KEY_FIRST) st_d = UL_HALF;
      UL_HALF: begin
        if (key_wr && wdata == KEY_SECOND)     st_d = UL_ARMED;
        else if (key_wr && wdata == KEY_FIRST) st_d = UL_HALF;
        else                                   st_d = UL_IDLE;
      end
      UL_ARMED: if (wr) st_d = (key_wr && wdata == KEY_FIRST) ? UL_HALF : UL_IDLE;
      default:  st_d = UL_IDLE;
    endcase
  end

  assign open_ok = (st_q == UL_ARMED) && ctrl_wr && !wdata[0] && !keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= UL_IDLE;
      lock_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (ctrl_wr && wdata[0]) lock_q <= 1'b1;
      else if (open_ok)        lock_q <= 1'b0;
    end
  end

  // R8: lock can only open from the armed state
  p_open_after_keys_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> $past(st_q == UL_ARMED));
  // R9: lock never opens while keep was high
  p_keep_holds_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> !$past(keep));
endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NPINS = 47,
  parameter int NIN   = 16,
  parameter int ADDR_W = 7,
  parameter logic [NPINS-1:0] INPUT_ONLY = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [MAP_W-1:0]             wcode,
  input  logic                         lock_q,
  output logic [DATA_W-1:0]            rdata,
  output logic [NPINS-1:0][MAP_W-1:0]  omap,
  output logic [NIN-1:0][MAP_W-1:0]    imap
);
  logic [DATA_W-1:0] rd_d;

  // Mapping registers: every mux reads its own code in parallel, so flops
  always_ff @(posedge clk) begin
    if (rst) begin
      omap <= '0;
      imap <= '1;
    end else if (wr && !lock_q) begin
      for (int p = 0; p < NPINS; p++)
        if (addr == ADDR_W'(OUT_BASE + p) && !INPUT_ONLY[p]) omap[p] <= wcode;
      for (int i = 0; i < NIN; i++)
        if (addr == ADDR_W'(IN_BASE + i)) imap[i] <= wcode;
    end
  end

  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NPINS; p++)
      if (addr == ADDR_W'(OUT_BASE + p)) rd_d = DATA_W'(omap[p]);
    for (int i = 0; i < NIN; i++)
      if (addr == ADDR_W'(IN_BASE + i)) rd_d = DATA_W'(imap[i]);
    if (addr == ADDR_W'(CTRL_ADDR)) rd_d = DATA_W'(lock_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  // R7: a write taken while locked changes no mapping
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr) |=> ($stable(omap) && $stable(imap)));
endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route
  import pinmux_pkg::*;
#(
  parameter int NPINS = 47,
  parameter int NGRP  = 4,
  parameter int PPG   = 12,
  parameter int IPG   = 4,
  parameter logic [NGRP*IPG-1:0] IN_IDLE = '0
) (
  input  logic [NGRP*IPG-1:0][MAP_W-1:0] imap,
  input  logic [NPINS-1:0]               pad_in,
  output logic [NGRP*IPG-1:0]            periph_in
);
  localparam int NIN = NGRP * IPG;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    localparam int G = i / IPG;
    logic [PPG-1:0] match, lvl;
    for (genvar j = 0; j < PPG; j++) begin : g_cand
      if (G * PPG + j < NPINS) begin : g_real
        assign match[j] = (imap[i] == MAP_W'(j));
        assign lvl[j]   = pad_in[G * PPG + j];
      end else begin : g_absent
        assign match[j] = 1'b0;
        assign lvl[j]   = 1'b0;
      end
    end
    assign periph_in[i] = (|match) ? |(match & lvl) : IN_IDLE[i];
  end
endmodule

// File: rtl/pinmux_out_arb.sv
module pinmux_out_arb
  import pinmux_pkg::*;
#(
  parameter int NPINS = 47,
  parameter int NGRP  = 4,
  parameter int PPG   = 12,
  parameter int OPG   = 4,
  parameter logic [NPINS-1:0] INPUT_ONLY = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPINS-1:0][MAP_W-1:0]  omap,
  input  logic [NGRP*OPG-1:0]          periph_out,
  input  logic [NGRP*OPG-1:0]          periph_oe,
  input  logic [NPINS-1:0]             fixed_out,
  input  logic [NPINS-1:0]             fixed_oe,
  input  logic [NPINS-1:0]             analog_en,
  output logic [NPINS-1:0]             pad_out,
  output logic [NPINS-1:0]             pad_oe
);
  logic [NPINS-1:0] nxt_out, nxt_oe;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int G = p / PPG;
    logic [OPG-1:0] pick, pv, pe;
    logic remap;
    for (genvar k = 0; k < OPG; k++) begin : g_fn
      assign pick[k] = (omap[p] == MAP_W'(k + 1));
      assign pv[k]   = periph_out[G * OPG + k];
      assign pe[k]   = periph_oe[G * OPG + k];
    end
    // analog > remapped > fixed digital
    assign remap      = (|pick) && !INPUT_ONLY[p];
    assign nxt_out[p] = remap ? |(pick & pv) : fixed_out[p];
    assign nxt_oe[p]  = !INPUT_ONLY[p] && !analog_en[p] &&
                        (remap ? |(pick & pe) : fixed_oe[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  // R5: analog pads never drive on the following cycle
  p_analog_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & $past(analog_en)) == '0));
  // R6: receive-only pads never drive
  p_inonly_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & INPUT_ONLY) == '0));
endmodule

// File: rtl/pinmux_xbar.sv
module pinmux_xbar
  import pinmux_pkg::*;
#(
  parameter int NPINS  = 47,
  parameter int NGRP   = 4,
  parameter int PPG    = 12,
  parameter int OPG    = 4,
  parameter int IPG    = 4,
  parameter int ADDR_W = 7,
  parameter logic [NPINS-1:0] INPUT_ONLY = 47'h3E00_0000_0000,
  parameter logic [NGRP*IPG-1:0] IN_IDLE = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   lock_keep,
  input  logic [NPINS-1:0]       pad_in,
  input  logic [NPINS-1:0]       analog_en,
  input  logic [NPINS-1:0]       fixed_out,
  input  logic [NPINS-1:0]       fixed_oe,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  input  logic [NGRP*OPG-1:0]    periph_out,
  input  logic [NGRP*OPG-1:0]    periph_oe,
  output logic [NGRP*IPG-1:0]    periph_in
);
  localparam int NIN = NGRP * IPG;

  logic                        lock_q;
  logic [NPINS-1:0][MAP_W-1:0] omap;
  logic [NIN-1:0][MAP_W-1:0]   imap;

  pinmux_lock #(.ADDR_W(ADDR_W)) u_lock (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .keep(lock_keep), .lock_q(lock_q)
  );

  pinmux_regs #(.NPINS(NPINS), .NIN(NIN), .ADDR_W(ADDR_W),
                .INPUT_ONLY(INPUT_ONLY)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wcode(bus_wdata[MAP_W-1:0]), .lock_q(lock_q),
    .rdata(bus_rdata), .omap(omap), .imap(imap)
  );

  pinmux_in_route #(.NPINS(NPINS), .NGRP(NGRP), .PPG(PPG), .IPG(IPG),
                    .IN_IDLE(IN_IDLE)) u_in (
    .imap(imap), .pad_in(pad_in), .periph_in(periph_in)
  );

  pinmux_out_arb #(.NPINS(NPINS), .NGRP(NGRP), .PPG(PPG), .OPG(OPG),
                   .INPUT_ONLY(INPUT_ONLY)) u_out (
    .clk(clk), .rst(rst), .omap(omap), .periph_out(periph_out),
    .periph_oe(periph_oe), .fixed_out(fixed_out), .fixed_oe(fixed_oe),
    .analog_en(analog_en), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/tb_pinmux_xbar.sv
module tb_pinmux_xbar;
  localparam int NP = 47, PPG = 12, OPG = 4, IPG = 4, NIN = 16, NOUT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            bus_wr = 1'b0;
  logic [6:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            lock_keep = 1'b0;
  logic [NP-1:0]   pad_in = '0, analog_en = '0, fixed_out = '0, fixed_oe = '0;
  logic [NP-1:0]   pad_out, pad_oe;
  logic [NOUT-1:0] periph_out = '0, periph_oe = '0;
  logic [NIN-1:0]  periph_in;

  int checks = 0, fails = 0;
  bit done = 0;
  int om[NP];
  int im[NIN];
  bit locked;
  int rd;

  pinmux_xbar dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_keep(lock_keep),
    .pad_in(pad_in), .analog_en(analog_en), .fixed_out(fixed_out),
    .fixed_oe(fixed_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in)
  );

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit in_only(int p);
    return p >= 41 && p <= 45;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) begin
      int c = om[p];
      bit rem = c >= 1 && c <= OPG && !in_only(p);
      v[p] = rem ? periph_out[(p / PPG) * OPG + c - 1] : fixed_out[p];
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) begin
      int c = om[p];
      bit rem = c >= 1 && c <= OPG && !in_only(p);
      if (in_only(p) || analog_en[p]) v[p] = 1'b0;
      else v[p] = rem ? periph_oe[(p / PPG) * OPG + c - 1] : fixed_oe[p];
    end
    return v;
  endfunction

  function automatic logic [NIN-1:0] exp_pin();
    logic [NIN-1:0] v;
    for (int i = 0; i < NIN; i++) begin
      int pin = (i / IPG) * PPG + im[i];
      v[i] = (im[i] < PPG && pin < NP) ? pad_in[pin] : 1'b0;
    end
    return v;
  endfunction

  task automatic bus_write(int a, int d);
    bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = 8'(d);
    if (!locked) begin
      if (a < NP && !in_only(a)) om[a] = d & 15;
      else if (a >= 64 && a < 64 + NIN) im[a - 64] = d & 15;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    bus_wr = 1'b0; bus_addr = 7'(a);
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  task automatic unlock_seq();
    bus_write(126, 'h55);
    bus_write(126, 'hAA);
    bus_write(127, 0);
  endtask

  task automatic rand_stim();
    pad_in     = NP'({$urandom, $urandom});
    analog_en  = NP'({$urandom, $urandom}) & NP'({$urandom, $urandom});
    fixed_out  = NP'({$urandom, $urandom});
    fixed_oe   = NP'({$urandom, $urandom});
    periph_out = NOUT'($urandom);
    periph_oe  = NOUT'($urandom);
  endtask

  task automatic settle_check(string req);
    @(negedge clk);
    check_eq(req, "pad_out", 64'(pad_out), 64'(exp_out()));
    check_eq(req, "pad_oe", 64'(pad_oe), 64'(exp_oe()));
    check_eq(req, "periph_in", 64'(periph_in), 64'(exp_pin()));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) om[p] = 0;
    for (int i = 0; i < NIN; i++) im[i] = 15;
    locked = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rand_stim();
    settle_check("R1");
    bus_read(127, rd); check_eq("R1", "lock after reset", 64'(rd), 64'd1);
    bus_read(3, rd);   check_eq("R1", "out map reset", 64'(rd), 64'd0);
    bus_read(64, rd);  check_eq("R1", "in map reset", 64'(rd), 64'h0F);

    // R7: writes while locked are dropped
    bus_write(5, 3);
    bus_read(5, rd); check_eq("R7", "locked write", 64'(rd), 64'd0);

    // R8: gap between key bytes restarts
    bus_write(126, 'h55);
    @(negedge clk);
    bus_write(126, 'hAA);
    bus_write(127, 0);
    bus_read(127, rd); check_eq("R8", "gap in keys", 64'(rd), 64'd1);
    // R8: foreign write before the clear restarts
    bus_write(126, 'h55);
    bus_write(126, 'hAA);
    bus_write(10, 1);
    bus_write(127, 0);
    bus_read(127, rd); check_eq("R8", "write between keys and clear", 64'(rd), 64'd1);

    // R9: keep input blocks opening
    lock_keep = 1'b1;
    unlock_seq();
    bus_read(127, rd); check_eq("R9", "kept lock", 64'(rd), 64'd1);
    lock_keep = 1'b0;

    // R8: proper sequence opens
    unlock_seq();
    locked = 0;
    bus_read(127, rd); check_eq("R8", "lock opened", 64'(rd), 64'd0);

    // R6: receive-only pad
    bus_write(42, 1);
    bus_read(42, rd); check_eq("R6", "input-only map", 64'(rd), 64'd0);
    fixed_oe = '1; analog_en = '0; periph_oe = '1;
    settle_check("R6");
    check_eq("R6", "input-only oe", 64'(pad_oe[45:41]), 64'd0);

    // R4: remapped output on pad 13 (group 1, code 2 -> output 5)
    bus_write(13, 2);
    periph_out = '0; periph_out[5] = 1'b1; periph_oe = '0; periph_oe[5] = 1'b1;
    fixed_out[13] = 1'b0; fixed_oe[13] = 1'b0;
    settle_check("R4");
    check_eq("R4", "pad13 out", 64'(pad_out[13]), 64'd1);
    check_eq("R4", "pad13 oe", 64'(pad_oe[13]), 64'd1);
    // R5: analog overrides
    analog_en[13] = 1'b1;
    settle_check("R5");
    check_eq("R5", "pad13 oe analog", 64'(pad_oe[13]), 64'd0);
    analog_en = '0;

    // R2: out-of-group code falls back to fixed, code 4 picks output 3
    bus_write(0, 7);
    fixed_out[0] = 1'b1; fixed_oe[0] = 1'b1;
    settle_check("R2");
    check_eq("R2", "pad0 code7", 64'(pad_out[0]), 64'd1);
    bus_write(0, 4);
    periph_out[3] = 1'b0; periph_oe[3] = 1'b1;
    settle_check("R2");
    check_eq("R2", "pad0 code4", 64'(pad_out[0]), 64'd0);

    // R3: input 15, code 11 -> nonexistent pad 47; code 10 -> pad 46
    pad_in = '1;
    bus_write(64 + 15, 11);
    @(negedge clk);
    check_eq("R3", "missing pad idle", 64'(periph_in[15]), 64'd0);
    bus_write(64 + 15, 10);
    check_eq("R3", "pad46 routed", 64'(periph_in[15]), 64'd1);

    // R10: unused and key addresses read 0
    bus_read('h30, rd); check_eq("R10", "unused addr", 64'(rd), 64'd0);
    bus_read(126, rd);  check_eq("R10", "key addr", 64'(rd), 64'd0);

    // R2 R3 R4 R5 R10: random mappings and stimulus
    for (int it = 0; it < 300; it++) begin
      int nw = int'($urandom_range(0, 3));
      for (int w = 0; w < nw; w++) begin
        if ($urandom_range(0, 1) == 1) bus_write(int'($urandom_range(0, NP - 1)), int'($urandom_range(0, 15)));
        else bus_write(64 + int'($urandom_range(0, NIN - 1)), int'($urandom_range(0, 15)));
      end
      rand_stim();
      settle_check("R4");
      if (it % 10 == 0) begin
        int a = int'($urandom_range(0, NP - 1));
        bus_read(a, rd); check_eq("R10", "out map readback", 64'(rd), 64'(om[a]));
        a = int'($urandom_range(0, NIN - 1));
        bus_read(64 + a, rd); check_eq("R10", "in map readback", 64'(rd), 64'(im[a]));
      end
    end

    // R8 R7: relock then writes are ignored
    bus_write(127, 1);
    locked = 1;
    bus_read(127, rd); check_eq("R8", "relock", 64'(rd), 64'd1);
    bus_write(20, 5);
    bus_read(20, rd); check_eq("R7", "locked after relock", 64'(rd), 64'(om[20]));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule